// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It holds four 16-bit segment base registers: code, data, stack and extra. A request names where its offset came from: the instruction pointer, the stack or base pointer, a source data index, or a string destination index. The block picks the segment that goes with that kind of offset. It moves the chosen base up by four bit positions and adds the offset. Because the offset is 16 bits wide, each segment covers a 64 KB window.

An override input lets a request name a different segment. The override applies to every kind of offset except instruction fetches, which always use the code segment. The segment registers load through a single synchronous write port. The address path is purely combinational and reads the register contents as they stand before the next clock edge. Alongside the address, the block reports the index of the segment it used. That lets a surrounding datapath check permissions or track the access.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous reset clears all four segment registers to zero. With no write pending after reset, every request gives a physical address equal to its offset.
- R2: A write with `wr_en` high loads `wr_data` into the register indexed by `wr_sel` at the rising edge. Segment indices are code=0, data=1, stack=2 and extra=3. The other three registers keep their values.
- R3: `paddr` equals the selected segment value times 16, plus the offset.
- R4: A carry out of bit 19 is discarded, so addresses wrap modulo 2^20. For example, segment FFFFh with offset FFFFh gives 0FFEFh.
- R5: Offset source 0 (instruction pointer) selects the code segment, and `seg_idx` reports 0.
- R6: With no override, offset source 1 (stack or base pointer) selects the stack segment, and `seg_idx` reports 2.
- R7: With no override, offset source 2 (source data index) selects the data segment and reports 1. Offset source 3 (string destination) selects the extra segment and reports 3.
- R8: When `ovr_en` is high and the offset source is not 0, the segment indexed by `ovr_seg` replaces the default, and `seg_idx` equals `ovr_seg`.
- R9: When the offset source is 0, `ovr_en` and `ovr_seg` have no effect on `paddr` or `seg_idx`.
- R10: The address is combinational from the current register contents. In a cycle that writes a register, the output still uses the old value, and the new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Index of the segment register to write |
| wr_data | input | 16 | Value to load |
| ofs_src | input | 2 | Kind of offset: 0 instruction pointer, 1 stack/base pointer, 2 data index, 3 string destination |
| ofs | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Segment override request |
| ovr_seg | input | 2 | Segment index used when the override applies |
| paddr | output | 20 | Physical address |
| seg_idx | output | 2 | Index of the segment that formed the address |

## Verification
A register that failed to load, loaded into the wrong slot, or was not cleared by reset shows up at `paddr` on the first request that selects it after the faulty edge. That is usually within one cycle in a stream that spreads requests over all four kinds of offset. A fault in the selection logic shows in `seg_idx` in the same cycle, with no clock edge needed. A lost or extra carry shows only for base and offset pairs whose sum reaches or passes 100000h, so those pairs are driven on purpose. The reference model mirrors the segment contents and compares both outputs in the middle of every cycle, so a wrong state is reported in the cycle it first becomes visible.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   // Index of each segment register; the order is visible at wr_sel and seg_idx
   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_id_e;

   // Kind of offset presented with a request
   typedef enum logic [1:0] {
      SRC_IP      = 2'd0,
      SRC_STKPTR  = 2'd1,
      SRC_DATAIDX = 2'd2,
      SRC_STRDST  = 2'd3
   } ofs_src_e;

   localparam int unsigned SEG_COUNT = 4;
   localparam int unsigned SEG_IDX_W = 2;

   // Default segment that belongs with each kind of offset
   function automatic seg_id_e default_seg(input ofs_src_e src);
      seg_id_e r;
      case (src)
         SRC_IP:      r = SEG_CODE;
         SRC_STKPTR:  r = SEG_STACK;
         SRC_DATAIDX: r = SEG_DATA;
         SRC_STRDST:  r = SEG_EXTRA;
         default:     r = SEG_CODE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned NSEG  = SEG_COUNT,
   parameter int unsigned IDX_W = SEG_IDX_W
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_sel,
   input  logic [SEG_W-1:0]               wr_data,
   output logic [NSEG-1:0][SEG_W-1:0]     seg_q
);

   generate
      if (NSEG > (1 << IDX_W)) begin : g_bad_idx
         $error("seg_regfile: IDX_W too narrow for NSEG");
      end
   endgenerate

   // One register per segment, each with its own write decode
   generate
      for (genvar g = 0; g < NSEG; g++) begin : g_seg
         logic hit;
         assign hit = wr_en && (wr_sel == IDX_W'(g));
         always_ff @(posedge clk) begin
            if (rst) begin
               seg_q[g] <= '0;
            end else if (hit) begin
               seg_q[g] <= wr_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
(
   input  ofs_src_e src,
   input  logic     ovr_en,
   input  seg_id_e  ovr_seg,
   output seg_id_e  sel
);

   seg_id_e dflt;

   always_comb begin
      dflt = default_seg(src);
      // Instruction fetches are pinned to the code segment
      if (ovr_en && (src != SRC_IP)) begin
         sel = ovr_seg;
      end else begin
         sel = dflt;
      end
   end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SHIFT     = 4,
   // 0: one full-width add; 1: low SHIFT bits bypass, add only the upper part
   parameter int unsigned ADD_STYLE = 1,
   localparam int unsigned PA_W     = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  paddr
);

   generate
      if (SHIFT < 1) begin : g_bad_shift
         $error("seg_adder: SHIFT must be at least 1");
      end
      if (OFS_W > PA_W) begin : g_bad_ofs
         $error("seg_adder: offset wider than the physical address");
      end
      if (OFS_W <= SHIFT) begin : g_bad_ofs_narrow
         $error("seg_adder: offset must be wider than SHIFT");
      end
      if (ADD_STYLE > 1) begin : g_bad_style
         $error("seg_adder: unknown ADD_STYLE");
      end
   endgenerate

   generate
      if (ADD_STYLE == 0) begin : g_full
         // Carry out of the top bit falls off the PA_W-wide result
         assign paddr = {seg, {SHIFT{1'b0}}} + PA_W'(ofs);
      end else begin : g_split
         localparam int unsigned HI_W = OFS_W - SHIFT;
         logic [SEG_W-1:0] ofs_hi;
         assign ofs_hi = SEG_W'(ofs[OFS_W-1:SHIFT]);
         // Shifted base is zero below SHIFT, so those bits are the offset's
         assign paddr[SHIFT-1:0]    = ofs[SHIFT-1:0];
         assign paddr[PA_W-1:SHIFT] = seg + ofs_hi;
         if (HI_W > SEG_W) begin : g_bad_hi
            $error("seg_adder: offset high part wider than segment");
         end
      end
   endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter int unsigned ADD_STYLE = 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [1:0]             wr_sel,
   input  logic [SEG_W-1:0]       wr_data,
   input  logic [1:0]             ofs_src,
   input  logic [OFS_W-1:0]       ofs,
   input  logic                   ovr_en,
   input  logic [1:0]             ovr_seg,
   output logic [SEG_W+SHIFT-1:0] paddr,
   output logic [1:0]             seg_idx
);

   localparam int unsigned NSEG = SEG_COUNT;
   localparam int unsigned PA_W = SEG_W + SHIFT;

   generate
      if (SEG_W < 2) begin : g_bad_segw
         $error("seg_addr_gen: SEG_W too small");
      end
   endgenerate

   logic [NSEG-1:0][SEG_W-1:0] seg_q;
   seg_id_e                    sel;
   logic [SEG_W-1:0]           seg_val;
   logic [PA_W-1:0]            sum;

   seg_regfile #(
      .SEG_W (SEG_W),
      .NSEG  (NSEG),
      .IDX_W (SEG_IDX_W)
   ) regs_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .seg_q   (seg_q)
   );

   seg_select sel_i (
      .src     (ofs_src_e'(ofs_src)),
      .ovr_en  (ovr_en),
      .ovr_seg (seg_id_e'(ovr_seg)),
      .sel     (sel)
   );

   assign seg_val = seg_q[sel];

   seg_adder #(
      .SEG_W     (SEG_W),
      .OFS_W     (OFS_W),
      .SHIFT     (SHIFT),
      .ADD_STYLE (ADD_STYLE)
   ) add_i (
      .seg   (seg_val),
      .ofs   (ofs),
      .paddr (sum)
   );

   assign paddr   = sum;
   assign seg_idx = sel;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned NSEG  = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       wr_en,
   input logic [1:0]                 wr_sel,
   input logic [SEG_W-1:0]           wr_data,
   input logic [1:0]                 ofs_src,
   input logic                       ovr_en,
   input logic [1:0]                 ovr_seg,
   input logic [1:0]                 seg_idx,
   input logic [NSEG-1:0][SEG_W-1:0] seg_q
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (seg_q == '0));

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (seg_q[$past(wr_sel)] == $past(wr_data)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(seg_q));

   // R5
   ip_code_chk: assert property (@(posedge clk) disable iff (rst)
      (ofs_src == 2'd0) |-> (seg_idx == 2'd0));

   // R6
   stack_dflt_chk: assert property (@(posedge clk) disable iff (rst)
      (!ovr_en && ofs_src == 2'd1) |-> (seg_idx == 2'd2));

   // R7
   data_dflt_chk: assert property (@(posedge clk) disable iff (rst)
      (!ovr_en && ofs_src == 2'd2) |-> (seg_idx == 2'd1));

   // R7
   extra_dflt_chk: assert property (@(posedge clk) disable iff (rst)
      (!ovr_en && ofs_src == 2'd3) |-> (seg_idx == 2'd3));

   // R8
   ovr_apply_chk: assert property (@(posedge clk) disable iff (rst)
      (ovr_en && ofs_src != 2'd0) |-> (seg_idx == ovr_seg));

   // R9
   ovr_ip_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (ovr_en && ofs_src == 2'd0) |-> (seg_idx == 2'd0));

endmodule

bind seg_addr_gen seg_addr_chk chk_i (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .ofs_src (ofs_src),
   .ovr_en  (ovr_en),
   .ovr_seg (ovr_seg),
   .seg_idx (seg_idx),
   .seg_q   (seg_q)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  ofs_src = '0;
   logic [15:0] ofs = '0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_seg = '0;
   logic [19:0] paddr;
   logic [1:0]  seg_idx;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // Reference state: one entry per segment, indexed code/data/stack/extra
   int unsigned seg_m [4];

   always #5 clk = ~clk;

   seg_addr_gen dut_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ofs_src (ofs_src),
      .ofs     (ofs),
      .ovr_en  (ovr_en),
      .ovr_seg (ovr_seg),
      .paddr   (paddr),
      .seg_idx (seg_idx)
   );

   function automatic int unsigned exp_idx(input logic [1:0] s, input logic oe,
                                           input logic [1:0] os);
      if (s == 2'd0) return 0;
      if (oe) return int'(os);
      case (s)
         2'd1:    return 2;
         2'd2:    return 1;
         default: return 3;
      endcase
   endfunction

   function automatic string auto_tag(input logic [1:0] s, input logic oe);
      if (s == 2'd0) return oe ? "R9" : "R5";
      if (oe) return "R8";
      if (s == 2'd1) return "R6";
      return "R7";
   endfunction

   task automatic check(input string tag, input int unsigned act, input int unsigned exp,
                        input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock: drive, compare mid-cycle, then advance the model at the edge
   task automatic cyc(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic [1:0] s, input logic [15:0] o, input logic oe,
                      input logic [1:0] os, input string tag);
      int unsigned ei;
      int unsigned ea;
      string t;
      wr_en = we; wr_sel = ws; wr_data = wd;
      ofs_src = s; ofs = o; ovr_en = oe; ovr_seg = os;
      @(negedge clk);
      ei = exp_idx(s, oe, os);
      ea = ((seg_m[ei] << 4) + int'(o)) & 32'h000F_FFFF;
      t = (tag == "") ? auto_tag(s, oe) : tag;
      check(t, 32'(seg_idx), ei, "seg_idx");
      check(t, 32'(paddr), ea, "paddr");
      @(posedge clk);
      if (we) seg_m[ws] = 32'(wd);
      #1;
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1;
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'hABCD;
      repeat (n) @(posedge clk);
      for (int i = 0; i < 4; i++) seg_m[i] = 0;
      #1;
      rst = 1'b0;
      wr_en = 1'b0;
   endtask

   initial begin
      do_reset(3);
      // R1: all segments read as zero after reset
      cyc(0, 0, 0, 2'd0, 16'h1234, 0, 0, "R1");
      cyc(0, 0, 0, 2'd1, 16'hFFFF, 0, 0, "R1");
      cyc(0, 0, 0, 2'd2, 16'h0001, 0, 0, "R1");
      cyc(0, 0, 0, 2'd3, 16'h8000, 0, 0, "R1");
      // R10: write cycle still shows the old code segment
      cyc(1, 2'd0, 16'h1234, 2'd0, 16'h0010, 0, 0, "R10");
      // R3 and R2: new value in the next cycle
      cyc(0, 0, 0, 2'd0, 16'h0010, 0, 0, "R3");
      cyc(1, 2'd1, 16'h2000, 2'd0, 16'h0003, 0, 0, "R2");
      cyc(1, 2'd2, 16'h3000, 2'd2, 16'h0004, 0, 0, "R2");
      cyc(1, 2'd3, 16'h4000, 2'd1, 16'h0005, 0, 0, "R2");
      // R5 R6 R7 defaults
      cyc(0, 0, 0, 2'd0, 16'h0100, 0, 0, "R5");
      cyc(0, 0, 0, 2'd1, 16'h0200, 0, 0, "R6");
      cyc(0, 0, 0, 2'd2, 16'h0300, 0, 0, "R7");
      cyc(0, 0, 0, 2'd3, 16'h0400, 0, 0, "R7");
      // R8 override on non-fetch sources
      cyc(0, 0, 0, 2'd1, 16'h0010, 1, 2'd3, "R8");
      cyc(0, 0, 0, 2'd2, 16'h0020, 1, 2'd0, "R8");
      cyc(0, 0, 0, 2'd3, 16'h0030, 1, 2'd2, "R8");
      // R9 override ignored for instruction pointer
      cyc(0, 0, 0, 2'd0, 16'h0040, 1, 2'd3, "R9");
      cyc(0, 0, 0, 2'd0, 16'h0050, 1, 2'd1, "R9");
      // R4 wrap at the top of the address space
      cyc(1, 2'd3, 16'hFFFF, 2'd3, 16'h0000, 0, 0, "R10");
      cyc(0, 0, 0, 2'd3, 16'hFFFF, 0, 0, "R4");
      cyc(1, 2'd2, 16'hF001, 2'd1, 16'h0000, 0, 0, "R2");
      cyc(0, 0, 0, 2'd1, 16'hFFF0, 0, 0, "R4");
      // R2 only the addressed register changed: read each back
      cyc(0, 0, 0, 2'd0, 16'h0000, 0, 0, "R2");
      cyc(0, 0, 0, 2'd2, 16'h0000, 0, 0, "R2");
      cyc(0, 0, 0, 2'd1, 16'h0000, 0, 0, "R2");
      cyc(0, 0, 0, 2'd3, 16'h0000, 0, 0, "R2");
      // Mixed stream
      for (int n = 0; n < 3000; n++) begin
         cyc(($urandom % 3) == 0, 2'($urandom), 16'($urandom),
             2'($urandom), 16'($urandom), ($urandom % 4) == 0, 2'($urandom), "");
      end
      // R1 again after a mid-run reset
      do_reset(2);
      for (int s = 0; s < 4; s++) begin
         cyc(0, 0, 0, 2'(s), 16'hC3C3, 0, 0, "R1");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule